// File: doc/BRIEF.md
# Serial Receive Holding Register with DMA Request

This block takes bytes from a serial deserialiser and holds each one in a data register, so that either software or a DMA channel can collect it. A receive-full flag marks an unread byte. The deserialiser can also report a framing error and a noise detection with the byte. The block flags these errors together with the byte. It also flags an overrun when a byte arrives while the previous one is still unread.

There are two ways to collect bytes. With DMA mode on, the full flag becomes a level DMA request. A single-cycle acknowledge from the DMA channel reads the byte and clears the full flag and all error flags. With DMA mode off, the full flag raises the receive interrupt, gated by its own enable. Software then reads the byte with a data-read strobe. To clear the error flags, software must issue a status-read strobe first and a data-read strobe after it. A separate enable sends any error flag to an error interrupt in either mode.

Top module: `rx_dma_bridge`

## Requirements
- R1: `dma_req` is never high while `cfg_dma_en` is low.
- R2: A byte strobed on `byte_vld` while `full_flag` is low appears on `data_q` in the next cycle, with `full_flag` high.
- R3: While `cfg_dma_en` is high, `dma_req` equals `full_flag`. It is a level that stays high until a read clears the flag.
- R4: A `dma_ack` pulse clears `full_flag`, and so `dma_req`, in the next cycle. It also clears `ferr_flag`, `nerr_flag` and `ovr_flag`.
- R5: `ferr_flag` and `nerr_flag` are set from `byte_ferr` and `byte_nerr` of an accepted byte, in the same cycle that `full_flag` rises for it. They are never set earlier. Once set, they stay set until a clear described in R4 or R7.
- R6: A byte that arrives while `full_flag` is high, with no `data_rd` or `dma_ack` in the same cycle, is dropped. Its error inputs are ignored, `data_q` keeps the unread byte, and `ovr_flag` is set. A byte that arrives in the same cycle as a read is accepted.
- R7: `data_rd` clears `full_flag`. It also clears the three error flags, but only if a `stat_rd` pulse came in an earlier cycle since the last `data_rd` or `dma_ack`.
- R8: `rx_irq` is high exactly when `cfg_dma_en` is low, `cfg_rx_ie` is high and `full_flag` is high.
- R9: `err_irq` is high exactly when `cfg_err_ie` is high and at least one of `ferr_flag`, `nerr_flag` or `ovr_flag` is set, in either mode.
- R10: While reset is applied, and after it, until the first byte arrives, all flags, `data_q`, `dma_req` and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| byte_vld | input | 1 | One-cycle strobe: a received byte is present |
| byte_data | input | DATA_W | Received byte |
| byte_ferr | input | 1 | Framing error seen on this byte |
| byte_nerr | input | 1 | Noise detected on this byte |
| cfg_dma_en | input | 1 | DMA receive mode enable |
| cfg_rx_ie | input | 1 | Receive interrupt enable (non-DMA mode) |
| cfg_err_ie | input | 1 | Error interrupt enable |
| stat_rd | input | 1 | Software status-read strobe |
| data_rd | input | 1 | Software data-register read strobe |
| dma_ack | input | 1 | DMA read strobe, acknowledges the request |
| data_q | output | DATA_W | Data register |
| full_flag | output | 1 | Receive-full flag |
| ferr_flag | output | 1 | Framing error flag |
| nerr_flag | output | 1 | Noise flag |
| ovr_flag | output | 1 | Overrun flag |
| dma_req | output | 1 | Level DMA request |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Error interrupt |

## Verification
The sweep covers every setting of the three control enables against every pairing of the framing and noise inputs, each with its own data value. This separates DMA routing from interrupt routing, and shows that each error bit maps to its own flag. In non-DMA runs, a bare data read comes before the status-then-data sequence. This shows whether errors stay set until the correct clear. Directed runs follow: a second byte into a full register, where the dropped byte carries a framing error, and a byte that arrives in the same cycle as the DMA acknowledge. Together they tell a dropped byte from an accepted one. A probe at the strobe cycle confirms that no flag appears before its byte.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int ERR_W   = 3;
  localparam int ERR_FRM = 0;
  localparam int ERR_NOI = 1;
  localparam int ERR_OVR = 2;
  typedef logic [ERR_W-1:0] err_vec_t;
endpackage

// File: rtl/rxdma_hold.sv
module rxdma_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              rd_clr,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q,
  output logic              accept,
  output logic              ovr_evt
);
  logic [DATA_W-1:0] data_d;
  logic              full_d;
  logic              data_en;

  always_comb begin
    accept  = byte_vld & (~full_q | rd_clr);
    ovr_evt = byte_vld & full_q & ~rd_clr;
    data_en = accept;
    data_d  = byte_data;
    if (accept)      full_d = 1'b1;
    else if (rd_clr) full_d = 1'b0;
    else             full_d = full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  // R2: an accepted byte lands in the register with the full flag
  p_load_sets_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !full_q) |=> (full_q && data_q == $past(byte_data)));

  // R6: a dropped byte leaves the register unchanged
  p_drop_keeps_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && full_q && !rd_clr) |=> ($stable(data_q) && full_q));
endmodule

// File: rtl/rxdma_errs.sv
module rxdma_errs
  import rxdma_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     accept,
  input  logic     ovr_evt,
  input  logic     byte_ferr,
  input  logic     byte_nerr,
  input  logic     stat_rd,
  input  logic     data_rd,
  input  logic     dma_ack,
  output err_vec_t err_q
);
  logic     armed_q, armed_d;
  logic     clr_all;
  err_vec_t set_ev;
  err_vec_t err_d;

  always_comb begin
    clr_all          = dma_ack | (data_rd & armed_q);
    set_ev           = '0;
    set_ev[ERR_FRM]  = accept & byte_ferr;
    set_ev[ERR_NOI]  = accept & byte_nerr;
    set_ev[ERR_OVR]  = ovr_evt;
    if (stat_rd)                armed_d = 1'b1;
    else if (data_rd | dma_ack) armed_d = 1'b0;
    else                        armed_d = armed_q;
  end

  for (genvar i = 0; i < ERR_W; i++) begin : g_flag
    always_comb begin
      if (set_ev[i])    err_d[i] = 1'b1;
      else if (clr_all) err_d[i] = 1'b0;
      else              err_d[i] = err_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        err_q[i] <= 1'b0;
      end else begin
        err_q[i] <= err_d[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

  // R7: a bare data read without a prior status read leaves flags alone
  p_bare_read_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !armed_q && !dma_ack && !accept && !ovr_evt) |=> $stable(err_q));

  // R6: overrun event always sets the overrun flag
  p_ovr_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> err_q[ERR_OVR]);
endmodule

// File: rtl/rxdma_route.sv
module rxdma_route
  import rxdma_pkg::*;
(
  input  logic     full_q,
  input  err_vec_t err_q,
  input  logic     cfg_dma_en,
  input  logic     cfg_rx_ie,
  input  logic     cfg_err_ie,
  output logic     dma_req,
  output logic     rx_irq,
  output logic     err_irq
);
  always_comb begin
    dma_req = cfg_dma_en & full_q;
    rx_irq  = ~cfg_dma_en & cfg_rx_ie & full_q;
    err_irq = cfg_err_ie & (|err_q);
  end
endmodule

// File: rtl/rx_dma_bridge.sv
module rx_dma_bridge
  import rxdma_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              byte_ferr,
  input  logic              byte_nerr,
  input  logic              cfg_dma_en,
  input  logic              cfg_rx_ie,
  input  logic              cfg_err_ie,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              dma_ack,
  output logic [DATA_W-1:0] data_q,
  output logic              full_flag,
  output logic              ferr_flag,
  output logic              nerr_flag,
  output logic              ovr_flag,
  output logic              dma_req,
  output logic              rx_irq,
  output logic              err_irq
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic                   accept, ovr_evt, rd_clr;
  err_vec_t               err_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_rsync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rst_sync_q[s] <= 1'b0;
      end else begin
        rst_sync_q[s] <= (s == 0) ? 1'b1 : rst_sync_q[(s == 0) ? 0 : s-1];
      end
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];
  assign rd_clr    = data_rd | dma_ack;

  rxdma_hold #(.DATA_W(DATA_W)) i_hold (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .rd_clr    (rd_clr),
    .data_q    (data_q),
    .full_q    (full_flag),
    .accept    (accept),
    .ovr_evt   (ovr_evt)
  );

  rxdma_errs i_errs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .accept    (accept),
    .ovr_evt   (ovr_evt),
    .byte_ferr (byte_ferr),
    .byte_nerr (byte_nerr),
    .stat_rd   (stat_rd),
    .data_rd   (data_rd),
    .dma_ack   (dma_ack),
    .err_q     (err_q)
  );

  rxdma_route i_route (
    .full_q     (full_flag),
    .err_q      (err_q),
    .cfg_dma_en (cfg_dma_en),
    .cfg_rx_ie  (cfg_rx_ie),
    .cfg_err_ie (cfg_err_ie),
    .dma_req    (dma_req),
    .rx_irq     (rx_irq),
    .err_irq    (err_irq)
  );

  assign ferr_flag = err_q[ERR_FRM];
  assign nerr_flag = err_q[ERR_NOI];
  assign ovr_flag  = err_q[ERR_OVR];

  // R1: no request while DMA mode is off
  p_no_req_off_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cfg_dma_en |-> !dma_req);

  // R4: acknowledge with no new byte empties the register and errors
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dma_ack && !byte_vld) |=> (!full_flag && !dma_req && !ferr_flag && !nerr_flag && !ovr_flag));

  // R8: receive interrupt is silent in DMA mode
  p_no_rxirq_dma_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_dma_en |-> !rx_irq);

  // R5: error flags never rise without a byte or overrun
  p_ferr_needs_byte_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!byte_vld && !ferr_flag) |=> !ferr_flag);
endmodule

// File: tb/test_rx_dma_bridge.sv
module test_rx_dma_bridge;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          byte_vld, byte_ferr, byte_nerr;
  logic [DW-1:0] byte_data;
  logic          cfg_dma_en, cfg_rx_ie, cfg_err_ie;
  logic          stat_rd, data_rd, dma_ack;
  logic [DW-1:0] data_q;
  logic          full_flag, ferr_flag, nerr_flag, ovr_flag;
  logic          dma_req, rx_irq, err_irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rx_dma_bridge #(.DATA_W(DW)) i_rx_dma_bridge (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .byte_ferr(byte_ferr), .byte_nerr(byte_nerr), .cfg_dma_en(cfg_dma_en),
    .cfg_rx_ie(cfg_rx_ie), .cfg_err_ie(cfg_err_ie), .stat_rd(stat_rd),
    .data_rd(data_rd), .dma_ack(dma_ack), .data_q(data_q),
    .full_flag(full_flag), .ferr_flag(ferr_flag), .nerr_flag(nerr_flag),
    .ovr_flag(ovr_flag), .dma_req(dma_req), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // Pack outputs: {full, ferr, nerr, ovr, dma_req, rx_irq, err_irq}
  function automatic int flags();
    return {25'd0, full_flag, ferr_flag, nerr_flag, ovr_flag, dma_req, rx_irq, err_irq};
  endfunction

  function automatic int expf(bit f, bit fe, bit ne, bit ov, bit dma, bit rie, bit eie);
    return {25'd0, f, fe, ne, ov, dma & f, ~dma & rie & f, eie & (fe | ne | ov)};
  endfunction

  task automatic idle();
    byte_vld = 0; byte_ferr = 0; byte_nerr = 0; byte_data = '0;
    stat_rd = 0; data_rd = 0; dma_ack = 0;
  endtask

  // Apply strobes for one cycle at a falling edge; results visible at next falling edge
  task automatic cyc(bit v, logic [DW-1:0] d, bit fe, bit ne, bit sr, bit dr, bit ak);
    @(negedge clk);
    byte_vld = v; byte_data = d; byte_ferr = fe; byte_nerr = ne;
    stat_rd = sr; data_rd = dr; dma_ack = ak;
    @(negedge clk);
    idle();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog got=%0d exp=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    cfg_dma_en = 0; cfg_rx_ie = 1; cfg_err_ie = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset flags", flags(), 0);
    chk("R10 reset data", int'(data_q), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R10 after reset flags", flags(), 0);

    // Sweep: every enable setting x every error pairing
    for (int c = 0; c < 8; c++) begin
      for (int e = 0; e < 4; e++) begin
        logic [DW-1:0] d;
        bit dm, ri, ei, fe, ne;
        dm = c[0]; ri = c[1]; ei = c[2]; fe = e[0]; ne = e[1];
        d = DW'((c * 37 + e * 11 + 91) % 256);
        cfg_dma_en = dm; cfg_rx_ie = ri; cfg_err_ie = ei;
        @(negedge clk);
        byte_vld = 1; byte_data = d; byte_ferr = fe; byte_nerr = ne;
        #1 chk("R5 no early flag", {ferr_flag, nerr_flag}, 0);
        @(negedge clk);
        idle();
        chk("R2 data loaded", int'(data_q), int'(d));
        chk("R1 R3 R8 R9 flags after byte", flags(), expf(1, fe, ne, 0, dm, ri, ei));
        repeat (2) @(negedge clk);
        chk("R3 request held", flags(), expf(1, fe, ne, 0, dm, ri, ei));
        if (dm) begin
          cyc(0, '0, 0, 0, 0, 0, 1);
          chk("R4 ack clears", flags(), expf(0, 0, 0, 0, dm, ri, ei));
        end else begin
          cyc(0, '0, 0, 0, 0, 1, 0);
          chk("R7 bare read keeps errors", flags(), expf(0, fe, ne, 0, dm, ri, ei));
          cyc(0, '0, 0, 0, 1, 0, 0);
          cyc(0, '0, 0, 0, 0, 1, 0);
          chk("R7 status then data clears", flags(), expf(0, 0, 0, 0, dm, ri, ei));
        end
      end
    end

    // Overrun in DMA mode; the dropped byte carries a framing error
    cfg_dma_en = 1; cfg_rx_ie = 0; cfg_err_ie = 1;
    cyc(1, 8'hA5, 0, 0, 0, 0, 0);
    cyc(1, 8'h3C, 1, 0, 0, 0, 0);
    chk("R6 unread byte kept", int'(data_q), 'hA5);
    chk("R6 overrun flags", flags(), expf(1, 0, 0, 1, 1, 0, 1));
    cyc(0, '0, 0, 0, 0, 0, 1);
    chk("R4 ack clears overrun", flags(), expf(0, 0, 0, 0, 1, 0, 1));

    // Byte arriving in the same cycle as the acknowledge is accepted
    cyc(1, 8'h11, 0, 1, 0, 0, 0);
    cyc(1, 8'h77, 0, 0, 0, 0, 1);
    chk("R6 same-cycle byte data", int'(data_q), 'h77);
    chk("R6 same-cycle byte flags", flags(), expf(1, 0, 0, 0, 1, 0, 1));
    cyc(0, '0, 0, 0, 0, 0, 1);
    chk("R4 final clear", flags(), expf(0, 0, 0, 0, 1, 0, 1));

    // Non-DMA overrun then software clear
    cfg_dma_en = 0; cfg_rx_ie = 1; cfg_err_ie = 0;
    cyc(1, 8'h5A, 0, 0, 0, 0, 0);
    cyc(1, 8'hC3, 0, 1, 0, 0, 0);
    chk("R6 R9 overrun no err irq", flags(), expf(1, 0, 0, 1, 0, 1, 0));
    cyc(0, '0, 0, 0, 1, 0, 0);
    cyc(0, '0, 0, 0, 0, 1, 0);
    chk("R7 overrun cleared", flags(), expf(0, 0, 0, 0, 0, 1, 0));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule